// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is a slave device for a two-wire (I2C) bus that fronts a 256-byte internal byte array and behaves like a small serial EEPROM. It watches the bus through two-flop synchronizers on SCL and SDA. START and STOP are recognised as SDA edges while SCL is high. The block answers one 7-bit device address and drives SDA only by pulling it low through an output enable.

A write names an 8-bit word address and then carries one or more data bytes. The data bytes go into a 16-byte staging buffer and only the low four address bits advance, so a long burst wraps inside its page. On STOP the staged bytes are committed to the array together in one timed internal write cycle. During that cycle the device refuses its address, so a host can poll for completion. A read continues from the shared address counter, which advances over all eight bits and wraps from 255 to 0. A random read is a dummy write of the word address followed by a repeated START with the read bit set.

Top module: `eep_slave`

## Requirements
- R1: Out of reset the SDA output enable is low, no write cycle runs and every array byte reads 0xFF.
- R2: The device acknowledges only the address byte whose upper seven bits equal 1010 followed by the DEV_SEL parameter, with bit 0 as read(1)/write(0); any other address gets no acknowledge and no further response.
- R3: Each data byte of a write is acknowledged and staged at the current in-page position; after it only the low four address bits increment, so a seventeenth byte overwrites the first staged position of the same page.
- R4: Staged bytes reach the array only after STOP, in one internal write cycle lasting WRITE_CYCLES clocks; a STOP with no staged byte starts no cycle.
- R5: While the internal write cycle runs the device does not acknowledge its address; once it ends, the next address is acknowledged.
- R6: A word address written and then a repeated START with the read address returns the byte stored at that word address.
- R7: After each byte sent, a master acknowledge yields the byte at the next address, counting over all eight bits and wrapping from 255 to 0; a master no-acknowledge ends the read with SDA released.
- R8: A read that begins without a word address returns the byte one past the last address read or written.
- R9: A START arriving in the middle of a byte abandons that byte, which is neither staged nor written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The two functions that can meet in one cycle are the end of the internal write cycle and the decode of an incoming device address: when the timer expires the same clock that the eighth address bit is sampled, the acknowledge decision and the commit both happen. The bench provokes this by polling with the write address immediately after STOP and repeatedly until an acknowledge returns. Each poll is judged on two facts: at least one poll must go unacknowledged, and the first acknowledged poll must not complete earlier than the write-cycle length. The committed bytes are then read back and compared against an arithmetic model.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RD,
    ST_RD_ACK
  } state_t;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [2:0] scl_q;
  logic [2:0] sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_comb begin
    scl_s     = scl_q[1];
    sda_s     = sda_q[1];
    scl_rise  = scl_q[1] & ~scl_q[2];
    scl_fall  = ~scl_q[1] & scl_q[2];
    start_evt = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    stop_evt  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  end
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
  parameter int WRITE_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done,
  output logic [$clog2(WRITE_CYCLES+1)-1:0] wcnt
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);

  logic          busy_n;
  logic [CW-1:0] wcnt_n;

  always_comb begin
    busy_n = busy;
    wcnt_n = wcnt;
    done   = 1'b0;
    if (busy) begin
      if (wcnt == LAST) begin
        busy_n = 1'b0;
        wcnt_n = '0;
        done   = 1'b1;
      end else begin
        wcnt_n = wcnt + CW'(1);
      end
    end else if (go) begin
      busy_n = 1'b1;
      wcnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wcnt <= '0;
    end else begin
      busy <= busy_n;
      wcnt <= wcnt_n;
    end
  end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_in,
  input  logic              buf_wr,
  input  logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
  input  logic [7:0]        buf_data,
  input  logic              commit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              buf_any
);
  localparam int IW    = $clog2(PAGE_BYTES);
  localparam int PW    = ADDR_W - IW;
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]            mem   [DEPTH];
  logic [7:0]            pbuf  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [PAGE_BYTES-1:0] valid_n;
  logic [PW-1:0]         page;

  always_comb begin
    valid_n = valid;
    if (commit || buf_clr) begin
      valid_n = '0;
    end else if (buf_wr) begin
      valid_n[buf_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      page  <= '0;
    end else begin
      valid <= valid_n;
      if (buf_clr) page <= page_in;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_wr) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (valid[i]) mem[{page, IW'(i)}] <= pbuf[i];
      end
    end
  end

  always_comb begin
    rd_data = mem[rd_addr];
    buf_any = |valid;
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          PAGE_BYTES = 16,
  parameter logic [2:0]  DEV_SEL    = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output state_t            state,
  output logic [ADDR_W-1:0] addr,
  output logic              sda_oe,
  output logic              buf_clr,
  output logic              buf_wr,
  output logic [7:0]        wbyte
);
  localparam int IW = $clog2(PAGE_BYTES);

  state_t            state_n;
  logic [2:0]        bitcnt, bitcnt_n;
  logic [7:0]        shreg, shreg_n;
  logic [ADDR_W-1:0] addr_n;
  logic              rw, rw_n;
  logic              ack_on, ack_on_n;
  logic              oe_n;
  logic [2:0]        nxt_bit;

  always_comb begin
    state_n  = state;
    bitcnt_n = bitcnt;
    shreg_n  = shreg;
    addr_n   = addr;
    rw_n     = rw;
    ack_on_n = ack_on;
    oe_n     = sda_oe;
    buf_clr  = 1'b0;
    buf_wr   = 1'b0;
    wbyte    = {shreg[6:0], sda_s};
    nxt_bit  = ~(bitcnt + 3'd1);

    if (start_evt) begin
      state_n  = ST_DEV;
      bitcnt_n = '0;
      oe_n     = 1'b0;
      ack_on_n = 1'b0;
    end else if (stop_evt) begin
      state_n  = ST_IDLE;
      oe_n     = 1'b0;
      ack_on_n = 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg_n  = wbyte;
            bitcnt_n = bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (state == ST_DEV) begin
                if (wbyte[7:1] == {DEV_TYPE, DEV_SEL} && !busy) begin
                  rw_n    = wbyte[0];
                  state_n = ST_DEV_ACK;
                end else begin
                  state_n = ST_IDLE;
                end
              end else if (state == ST_WADDR) begin
                addr_n  = wbyte;
                buf_clr = 1'b1;
                state_n = ST_WADDR_ACK;
              end else begin
                buf_wr  = 1'b1;
                addr_n  = {addr[ADDR_W-1:IW], addr[IW-1:0] + IW'(1)};
                state_n = ST_WDATA_ACK;
              end
            end
          end
        end
        ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            if (!ack_on) begin
              ack_on_n = 1'b1;
              oe_n     = 1'b1;
            end else begin
              ack_on_n = 1'b0;
              oe_n     = 1'b0;
              bitcnt_n = '0;
              if (state == ST_DEV_ACK && rw) begin
                state_n = ST_RD;
                shreg_n = rd_data;
                oe_n    = ~rd_data[7];
              end else if (state == ST_DEV_ACK) begin
                state_n = ST_WADDR;
              end else begin
                state_n = ST_WDATA;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              oe_n    = 1'b0;
              addr_n  = addr + ADDR_W'(1);
              state_n = ST_RD_ACK;
            end else begin
              bitcnt_n = bitcnt + 3'd1;
              oe_n     = ~shreg[nxt_bit];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (sda_s) state_n = ST_IDLE;
            else       ack_on_n = 1'b1;
          end else if (scl_fall && ack_on) begin
            ack_on_n = 1'b0;
            bitcnt_n = '0;
            shreg_n  = rd_data;
            oe_n     = ~rd_data[7];
            state_n  = ST_RD;
          end
        end
        default: begin
          state_n = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      addr   <= '0;
      rw     <= 1'b0;
      ack_on <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      state  <= state_n;
      bitcnt <= bitcnt_n;
      shreg  <= shreg_n;
      addr   <= addr_n;
      rw     <= rw_n;
      ack_on <= ack_on_n;
      sda_oe <= oe_n;
    end
  end
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter int         PAGE_BYTES   = 16,
  parameter int         WRITE_CYCLES = 5000,
  parameter logic [2:0] DEV_SEL      = 3'b000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              busy, commit, buf_clr, buf_wr, buf_any;
  logic [CW-1:0]     wcnt;
  logic [7:0]        rd_data, wbyte;
  logic [ADDR_W-1:0] addr;
  state_t            state;
  logic              wc_go;

  assign wc_go = stop_evt & buf_any & ~busy;

  eep_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep_wcycle #(.WRITE_CYCLES(WRITE_CYCLES)) u_wc (
    .clk(clk), .rst_n(rst_n), .go(wc_go), .busy(busy), .done(commit), .wcnt(wcnt)
  );

  eep_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .page_in(wbyte[7:IW]),
    .buf_wr(buf_wr), .buf_idx(addr[IW-1:0]), .buf_data(wbyte),
    .commit(commit), .rd_addr(addr), .rd_data(rd_data), .buf_any(buf_any)
  );

  eep_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DEV_SEL(DEV_SEL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .busy(busy), .rd_data(rd_data), .state(state), .addr(addr),
    .sda_oe(sda_oe), .buf_clr(buf_clr), .buf_wr(buf_wr), .wbyte(wbyte)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              stop_evt,
  input logic              start_evt,
  input logic              buf_wr,
  input logic              scl_s,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] addr,
  input logic [$clog2(WRITE_CYCLES+1)-1:0] wcnt,
  input state_t            state
);
  localparam int IW = $clog2(PAGE_BYTES);

  // R4: a write cycle only ever begins on the clock after a STOP
  assert_cycle_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  // R4: the cycle counter never passes the configured length
  assert_cycle_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wcnt < WRITE_CYCLES));

  // R5: no address acknowledge phase is entered while busy
  assert_silent_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (state != ST_DEV_ACK || $past(state) == ST_DEV_ACK));

  // R3: staging a byte leaves the page bits of the counter unchanged
  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> (addr[ADDR_W-1:IW] == $past(addr[ADDR_W-1:IW])));

  // R7: the data line is only changed while the clock line is low
  assert_sda_moves_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R9: a START always restarts address reception
  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_DEV && !sda_oe));
endmodule

bind eep_slave eep_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .stop_evt(stop_evt),
  .start_evt(start_evt), .buf_wr(buf_wr), .scl_s(scl_s), .sda_oe(sda_oe),
  .addr(addr), .wcnt(wcnt), .state(state)
);

// File: tb/sim_eep_slave.sv
module sim_eep_slave;
  localparam int WC = 400;
  localparam int H  = 12;
  localparam int Q  = 6;

  logic clk, rst_n, m_scl, m_low;
  logic sda_oe;
  wire  sda_line = !(m_low || sda_oe);
  int   nvec, nfail, cyc;
  bit   done_flag;
  logic [7:0] model [256];

  eep_slave #(.WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_low = 1'b0; hw(Q); m_scl = 1'b1; hw(H);
    m_low = 1'b1; hw(H); m_scl = 1'b0; hw(Q);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; hw(Q); m_scl = 1'b1; hw(H);
    m_low = 1'b0; hw(H);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_low = !b; hw(Q); m_scl = 1'b1; hw(Q);
    s = sda_line; hw(Q); m_scl = 1'b0; hw(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      b = {b[6:0], s};
    end
    clk_bit(!mack, s);
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 37 + i * 11) ^ 8'h5A);
  endfunction

  task automatic poll(output logic ack);
    bus_start; send_byte(8'hA0, ack); bus_stop;
  endtask

  // R4/R5: poll from STOP until acknowledged; judge NACK count and elapsed time
  task automatic wait_ready(input string tag);
    logic ack;
    int t0, naks;
    t0 = cyc; naks = 0; ack = 1'b0;
    for (int k = 0; k < 200 && !ack; k++) begin
      poll(ack);
      if (!ack) naks++;
    end
    chk({tag, " R5 ack after cycle"}, ack, 1);
    chk({tag, " R5 nack while busy"}, naks > 0, 1);
    chk({tag, " R4 cycle length"}, (cyc - t0) >= WC, 1);
  endtask

  task automatic page_write(input logic [7:0] wa, input int n, input int seed);
    logic ack;
    logic [3:0] off;
    bus_start;
    send_byte(8'hA0, ack); chk("R2 write address ack", ack, 1);
    send_byte(wa, ack);    chk("R3 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      off = wa[3:0] + 4'(i);
      send_byte(pat(seed, i), ack);
      chk("R3 data byte ack", ack, 1);
      model[{wa[7:4], off}] = pat(seed, i);
    end
    bus_stop;
  endtask

  task automatic rand_read(input logic [7:0] wa, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start; send_byte(8'hA0, ack); send_byte(wa, ack);
    bus_start; send_byte(8'hA1, ack);
    chk({tag, " R6 read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(tag, b, model[8'(wa + i)]);
    end
    chk({tag, " R7 sda released after nack"}, sda_oe, 0);
    bus_stop;
  endtask

  task automatic imm_read(input logic [7:0] ea, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start; send_byte(8'hA1, ack);
    chk({tag, " ack"}, ack, 1);
    recv_byte(1'b0, b);
    chk(tag, b, model[ea]);
    bus_stop;
  endtask

  initial begin
    logic ack, s;
    nvec = 0; nfail = 0; cyc = 0; done_flag = 1'b0;
    m_scl = 1'b1; m_low = 1'b0; rst_n = 1'b0;
    for (int a = 0; a < 256; a++) model[a] = 8'hFF;
    hw(5);
    chk("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    hw(5);
    chk("R1 sda_oe after reset", sda_oe, 0);

    rand_read(8'h00, 1, "R1 erased byte");

    // R2: foreign address ignored, for every other device select value
    for (int sel = 1; sel < 8; sel++) begin
      bus_start; send_byte({4'b1010, 3'(sel), 1'b0}, ack); bus_stop;
      chk("R2 foreign select nack", ack, 0);
    end
    bus_start; send_byte(8'h30, ack); bus_stop;
    chk("R2 foreign type nack", ack, 0);

    // R3/R4/R5: single byte write, then poll
    page_write(8'h10, 1, 3);
    wait_ready("byte write");
    rand_read(8'h10, 1, "R6 random read after byte write");
    imm_read(8'h11, "R8 immediate read follows last read");

    // R8 after a write: counter sits one past the written byte inside the page
    page_write(8'h2F, 1, 9);
    wait_ready("edge write");
    imm_read(8'h20, "R8 immediate read after in-page wrap");

    // R3: 20 bytes wrap within page 0x30
    page_write(8'h35, 20, 5);
    wait_ready("page wrap");
    rand_read(8'h30, 16, "R3 wrapped page contents");

    // R4: STOP without data starts no cycle
    bus_start; send_byte(8'hA0, ack); send_byte(8'h50, ack); bus_stop;
    poll(ack);
    chk("R4 no cycle without data", ack, 1);

    // R9: START in mid data byte abandons it
    bus_start; send_byte(8'hA0, ack); send_byte(8'h60, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_start; bus_stop;
    poll(ack);
    chk("R9 aborted byte starts no cycle", ack, 1);
    rand_read(8'h60, 1, "R9 aborted byte not stored");

    // Sweep: every page written from a rotating offset, then read whole array
    for (int p = 0; p < 16; p++) begin
      page_write(8'((p << 4) | p), 16, p + 20);
      wait_ready("sweep");
    end
    rand_read(8'h00, 258, "R7 sequential read with wrap");
    imm_read(8'h02, "R8 immediate read after wrap");

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      nvec++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule